// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating analog-to-digital converter. It steps the analog front end through one measurement cycle at a time. The cycle has four phases in a fixed order. Two offset-cancelling phases come first: auto-zero, then integrator-output zeroing. Next the input is integrated over a fixed span of clock cycles. Last, a reference of the opposite sign is applied until the integrator output returns through zero. For each phase there is one switch-enable output, and the block drives exactly one of them while a cycle is in progress.

The conversion itself happens only in the last two phases. The input level is proportional to the reference times the ratio of the two spans. The number of clocks counted while the reference is applied is therefore the magnitude of the result. The comparator level seen at the end of integration gives the input sign, which selects the reference polarity and is reported with the count. If no zero crossing arrives before a parameterised limit, the cycle stops with a saturated count and an overrange flag.

The lengths of the three timed phases are written through a parallel load port while the block is idle. Setting the integrate length to a whole number of mains periods cancels line interference. Conversions are started one at a time by a start pulse, or they run back to back in continuous mode.

Top module: `dsadc_seq`

## Requirements
- R1: The phase enables are en_az, en_iz, en_int and en_deint. At most one of them is high in any cycle, and none is high while idle. A cycle always moves from auto-zero to integrator zero, then to integrate, then to de-integrate, with no phase skipped.
- R2: A start pulse seen while idle makes en_az high in the very next cycle. Start has no effect while a conversion is running.
- R3: The auto-zero, integrator-zero and integrate phases each last exactly their programmed length in clock cycles. A programmed length of 0 counts as 1.
- R4: cfg_we loads the three lengths only while idle. A write made during a conversion changes no later phase length.
- R5: The comparator level, after the synchronizer, is captured on the last integrate cycle. When it is 1 (input positive), ref_neg is high for every de-integrate cycle. ref_neg is never high outside de-integrate. result_neg is the inverse of the captured level.
- R6: cmp_in passes through a two-stage synchronizer. De-integrate cycles are indexed from 0. If cmp_in leaves its captured level during de-integrate cycle j, the result is j+2, and de-integrate lasts j+3 cycles.
- R7: If no crossing is seen by index MAX_DEINT, the result is MAX_DEINT and result_ovr is 1, and de-integrate lasts MAX_DEINT+1 cycles. A crossing seen at index MAX_DEINT itself gives result MAX_DEINT with result_ovr at 0.
- R8: result_valid is high for exactly one cycle: the cycle right after the last de-integrate cycle. result, result_neg and result_ovr change only in that cycle.
- R9: With continuous high on the last de-integrate cycle, en_az is high in the same cycle as result_valid. Otherwise the block is idle in that cycle.
- R10: After reset the block is idle, with all enables, ref_neg, result_valid, result_ovr and result at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the phase lengths (accepted only while idle) |
| cfg_az_len | input | CNT_W | Auto-zero length in cycles |
| cfg_iz_len | input | CNT_W | Integrator-zero length in cycles |
| cfg_int_len | input | CNT_W | Integrate length in cycles |
| start | input | 1 | Starts a conversion from idle |
| continuous | input | 1 | Restart a new cycle after each result |
| cmp_in | input | 1 | Asynchronous zero-crossing comparator output |
| en_az | output | 1 | Auto-zero switch enable |
| en_iz | output | 1 | Integrator-zero switch enable |
| en_int | output | 1 | Input-integrate switch enable |
| en_deint | output | 1 | Reference de-integrate switch enable |
| ref_neg | output | 1 | Selects the negative reference during de-integrate |
| result | output | CNT_W | De-integrate count |
| result_neg | output | 1 | Sign of the input for the current result |
| result_ovr | output | 1 | Overrange flag for the current result |
| result_valid | output | 1 | One-cycle strobe for a new result |

## Verification
Two events can fall in the same de-integrate cycle: a zero crossing and the count reaching its overrange limit. The bench provokes this by moving the comparator exactly two cycles before index MAX_DEINT, so the synchronized change lands on the limit cycle. The expected outcome is a clean result equal to the limit with no overrange flag. The sweep of crossing positions brackets this case from both sides, expecting a plain count one position earlier and an overrange one position later. A second coincidence comes from continuous mode: the result strobe and the first auto-zero cycle of the next conversion fall in the same cycle, and the bench checks that both are present together.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_AZ    = 3'd1,
        PH_IZ    = 3'd2,
        PH_INT   = 3'd3,
        PH_DEINT = 3'd4
    } phase_e;

    localparam int NUM_ACTIVE_PHASES = 4;

endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_out = sh_q[STAGES-1];
endmodule

// File: rtl/dsadc_phase_dec.sv
module dsadc_phase_dec
    import dsadc_pkg::*;
(
    input  phase_e                       phase,
    input  logic                         pol,
    output logic [NUM_ACTIVE_PHASES-1:0] en,
    output logic                         ref_neg
);
    for (genvar i = 0; i < NUM_ACTIVE_PHASES; i++) begin : g_en
        assign en[i] = (phase == phase_e'(i + 1));
    end

    assign ref_neg = (phase == PH_DEINT) & pol;
endmodule

// File: rtl/dsadc_fsm.sv
module dsadc_fsm
    import dsadc_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int MAX_DEINT = 60000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_az_len,
    input  logic [CNT_W-1:0] cfg_iz_len,
    input  logic [CNT_W-1:0] cfg_int_len,
    input  logic             start,
    input  logic             continuous,
    input  logic             cmp_lvl,
    output phase_e           phase,
    output logic             pol,
    output logic [CNT_W-1:0] res,
    output logic             res_neg,
    output logic             res_ovr,
    output logic             res_vld
);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_DEINT);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             pol;
        logic [CNT_W-1:0] az_len;
        logic [CNT_W-1:0] iz_len;
        logic [CNT_W-1:0] int_len;
        logic [CNT_W-1:0] res;
        logic             res_neg;
        logic             res_ovr;
        logic             res_vld;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [CNT_W-1:0] last_idx(input logic [CNT_W-1:0] len);
        return (len == '0) ? '0 : len - ONE_C;
    endfunction

    logic az_last, iz_last, int_last, done;

    always_comb begin
        st_d     = st_q;
        st_d.res_vld = 1'b0;
        done     = 1'b0;
        az_last  = (st_q.cnt == last_idx(st_q.az_len));
        iz_last  = (st_q.cnt == last_idx(st_q.iz_len));
        int_last = (st_q.cnt == last_idx(st_q.int_len));

        unique case (st_q.phase)
            PH_IDLE: begin
                if (cfg_we) begin
                    st_d.az_len  = cfg_az_len;
                    st_d.iz_len  = cfg_iz_len;
                    st_d.int_len = cfg_int_len;
                end
                if (start) begin
                    st_d.phase = PH_AZ;
                    st_d.cnt   = '0;
                end
            end
            PH_AZ: begin
                if (az_last) begin
                    st_d.phase = PH_IZ;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + ONE_C;
                end
            end
            PH_IZ: begin
                if (iz_last) begin
                    st_d.phase = PH_INT;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + ONE_C;
                end
            end
            PH_INT: begin
                if (int_last) begin
                    st_d.phase = PH_DEINT;
                    st_d.cnt   = '0;
                    st_d.pol   = cmp_lvl;
                end else begin
                    st_d.cnt = st_q.cnt + ONE_C;
                end
            end
            PH_DEINT: begin
                if (cmp_lvl != st_q.pol) begin
                    done        = 1'b1;
                    st_d.res    = st_q.cnt;
                    st_d.res_ovr = 1'b0;
                end else if (st_q.cnt == MAX_C) begin
                    done        = 1'b1;
                    st_d.res    = MAX_C;
                    st_d.res_ovr = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + ONE_C;
                end
                if (done) begin
                    st_d.res_vld = 1'b1;
                    st_d.res_neg = ~st_q.pol;
                    st_d.cnt     = '0;
                    st_d.phase   = continuous ? PH_AZ : PH_IDLE;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.phase   <= PH_IDLE;
            st_q.az_len  <= ONE_C;
            st_q.iz_len  <= ONE_C;
            st_q.int_len <= ONE_C;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase   = st_q.phase;
    assign pol     = st_q.pol;
    assign res     = st_q.res;
    assign res_neg = st_q.res_neg;
    assign res_ovr = st_q.res_ovr;
    assign res_vld = st_q.res_vld;
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
    import dsadc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int MAX_DEINT   = 60000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_az_len,
    input  logic [CNT_W-1:0] cfg_iz_len,
    input  logic [CNT_W-1:0] cfg_int_len,
    input  logic             start,
    input  logic             continuous,
    input  logic             cmp_in,
    output logic             en_az,
    output logic             en_iz,
    output logic             en_int,
    output logic             en_deint,
    output logic             ref_neg,
    output logic [CNT_W-1:0] result,
    output logic             result_neg,
    output logic             result_ovr,
    output logic             result_valid
);
    logic                         cmp_lvl;
    phase_e                       phase;
    logic                         pol;
    logic [NUM_ACTIVE_PHASES-1:0] en;

    dsadc_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (cmp_in),
        .q_out (cmp_lvl)
    );

    dsadc_fsm #(.CNT_W(CNT_W), .MAX_DEINT(MAX_DEINT)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_az_len  (cfg_az_len),
        .cfg_iz_len  (cfg_iz_len),
        .cfg_int_len (cfg_int_len),
        .start       (start),
        .continuous  (continuous),
        .cmp_lvl     (cmp_lvl),
        .phase       (phase),
        .pol         (pol),
        .res         (result),
        .res_neg     (result_neg),
        .res_ovr     (result_ovr),
        .res_vld     (result_valid)
    );

    dsadc_phase_dec dec_i (
        .phase   (phase),
        .pol     (pol),
        .en      (en),
        .ref_neg (ref_neg)
    );

    assign en_az    = en[0];
    assign en_iz    = en[1];
    assign en_int   = en[2];
    assign en_deint = en[3];
endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
    parameter int CNT_W     = 16,
    parameter int MAX_DEINT = 60000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             continuous,
    input logic             en_az,
    input logic             en_iz,
    input logic             en_int,
    input logic             en_deint,
    input logic             ref_neg,
    input logic [CNT_W-1:0] result,
    input logic             result_neg,
    input logic             result_ovr,
    input logic             result_valid
);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_DEINT);

    AST_ONE_PHASE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en_az, en_iz, en_int, en_deint})); // R1
    AST_AZ_THEN_IZ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_az) |-> en_iz); // R1
    AST_IZ_THEN_INT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_iz) |-> en_int); // R1
    AST_INT_THEN_DEINT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_int) |-> en_deint); // R1
    AST_REF_IN_DEINT: assert property (@(posedge clk) disable iff (!rst_n)
        ref_neg |-> en_deint); // R5
    AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        result <= MAX_C); // R6
    AST_OVR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && result_ovr) |-> (result == MAX_C)); // R7
    AST_VALID_AFTER_DEINT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_deint) |-> result_valid); // R8
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> ($stable(result) && $stable(result_neg) && $stable(result_ovr))); // R8
    AST_CONT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && $past(continuous)) |-> en_az); // R9
    AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !$past(continuous)) |-> !en_az); // R9
endmodule

bind dsadc_seq dsadc_seq_chk #(.CNT_W(CNT_W), .MAX_DEINT(MAX_DEINT)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .continuous   (continuous),
    .en_az        (en_az),
    .en_iz        (en_iz),
    .en_int       (en_int),
    .en_deint     (en_deint),
    .ref_neg      (ref_neg),
    .result       (result),
    .result_neg   (result_neg),
    .result_ovr   (result_ovr),
    .result_valid (result_valid)
);

// File: tb/dsadc_seq_tb_top.sv
module dsadc_seq_tb_top;
    localparam int CNT_W = 8;
    localparam int MAXD  = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [CNT_W-1:0] cfg_az_len = '0, cfg_iz_len = '0, cfg_int_len = '0;
    logic             start = 1'b0, continuous = 1'b0, cmp_in = 1'b0;
    logic             en_az, en_iz, en_int, en_deint, ref_neg;
    logic [CNT_W-1:0] result;
    logic             result_neg, result_ovr, result_valid;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dsadc_seq #(.CNT_W(CNT_W), .MAX_DEINT(MAXD), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
        .cfg_az_len(cfg_az_len), .cfg_iz_len(cfg_iz_len), .cfg_int_len(cfg_int_len),
        .start(start), .continuous(continuous), .cmp_in(cmp_in),
        .en_az(en_az), .en_iz(en_iz), .en_int(en_int), .en_deint(en_deint),
        .ref_neg(ref_neg), .result(result), .result_neg(result_neg),
        .result_ovr(result_ovr), .result_valid(result_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff(input int len);
        return (len == 0) ? 1 : len;
    endfunction

    // Runs one conversion starting at a negedge; j<0 means the comparator never moves.
    task automatic do_conv(input int az, input int iz, input int it, input bit pos,
                           input int j, input bit wr, input bit cont, input bit chain,
                           input bit poke);
        int n_az = 0, n_iz = 0, n_it = 0, n_de = 0, prev = 1;
        bit order_bad = 0, ref_bad = 0, got = 0;
        int e_res, e_de;
        bit e_ovr;
        if (wr) begin
            cfg_we = 1'b1; cfg_az_len = CNT_W'(az); cfg_iz_len = CNT_W'(iz); cfg_int_len = CNT_W'(it);
            @(negedge clk);
            cfg_we = 1'b0;
        end
        cmp_in = pos;
        continuous = cont;
        if (!chain) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(en_az == 1'b1, "R2 en_az after start", int'(en_az), 1);
        end
        for (int t = 0; t < 1000; t++) begin
            int cur;
            if (t > 0 && result_valid) begin got = 1; break; end
            cur = en_az ? 1 : en_iz ? 2 : en_int ? 3 : en_deint ? 4 : 0;
            if ($countones({en_az, en_iz, en_int, en_deint}) != 1) order_bad = 1;
            if (cur != prev && cur != prev + 1) order_bad = 1;
            prev = cur;
            if (en_az) n_az++;
            if (en_iz) n_iz++;
            if (en_int) n_it++;
            if (en_deint) begin
                if (ref_neg != pos) ref_bad = 1;
                if (n_de == j) cmp_in = ~pos;
                n_de++;
            end else if (ref_neg) ref_bad = 1;
            if (poke && t == 1) begin
                cfg_we = 1'b1; start = 1'b1;
                cfg_az_len = 8'd7; cfg_iz_len = 8'd7; cfg_int_len = 8'd7;
            end
            if (poke && t == 2) begin cfg_we = 1'b0; start = 1'b0; end
            @(negedge clk);
        end
        if (j >= 0 && j + 2 <= MAXD) begin e_res = j + 2; e_ovr = 0; e_de = j + 3; end
        else begin e_res = MAXD; e_ovr = 1; e_de = MAXD + 1; end
        chk(got, "R8 result_valid seen", int'(got), 1);
        chk(!order_bad, "R1 phase order/one-hot", int'(order_bad), 0);
        chk(n_az == eff(az), "R3 auto-zero length", n_az, eff(az));
        chk(n_iz == eff(iz), "R3 izero length", n_iz, eff(iz));
        chk(n_it == eff(it), "R3 integrate length", n_it, eff(it));
        chk(!ref_bad, "R5 ref_neg follows sign", int'(ref_bad), 0);
        chk(n_de == e_de, "R6 deint length", n_de, e_de);
        chk(int'(result) == e_res, "R6 result", int'(result), e_res);
        chk(result_ovr == e_ovr, "R7 overrange", int'(result_ovr), int'(e_ovr));
        chk(result_neg == ~pos, "R5 sign", int'(result_neg), int'(~pos));
        chk(en_az == cont, "R9 restart vs idle", int'(en_az), int'(cont));
        if (!cont) begin
            @(negedge clk);
            chk(!result_valid && !en_az, "R8 strobe width", int'(result_valid), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!en_az && !en_iz && !en_int && !en_deint && !ref_neg, "R10 enables at reset",
            int'({en_az, en_iz, en_int, en_deint}), 0);
        chk(!result_valid && !result_ovr && result == '0, "R10 result at reset", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!en_az, "R10 idle after reset", int'(en_az), 0);

        // Sweep lengths, sign and crossing position including the limit coincidence (R7).
        for (int az = 0; az < 4; az++)
            for (int iz = 1; iz < 3; iz++)
                for (int it = 1; it < 6; it += 2)
                    for (int p = 0; p < 2; p++)
                        for (int j = -1; j < MAXD; j++)
                            do_conv(az, iz, it, p[0], j, 1'b1, 1'b0, 1'b0, 1'b0);

        // R4 / R2: config writes and start while busy are ignored.
        do_conv(2, 2, 2, 1'b1, 5, 1'b1, 1'b0, 1'b0, 1'b1);
        do_conv(2, 2, 2, 1'b0, 3, 1'b0, 1'b0, 1'b0, 1'b0);

        // R9: continuous chain of three, last one stops.
        do_conv(1, 1, 4, 1'b1, 4, 1'b1, 1'b1, 1'b0, 1'b0);
        do_conv(1, 1, 4, 1'b0, MAXD - 2, 1'b0, 1'b1, 1'b1, 1'b0);
        do_conv(1, 1, 4, 1'b1, -1, 1'b0, 1'b0, 1'b1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule